// File: doc/BRIEF.md
# Byte-Masked Write Controller with SEC-DED Protection

This block sits between a single requester and a synchronous memory that stores 72-bit words. Every 64-bit data word is kept with 8 check bits of an odd-weight-column single-error-correct, double-error-detect code. A write request whose byte mask selects all eight bytes is encoded and stored in one memory write cycle. A write that selects fewer bytes first reads and checks the stored word, then substitutes the selected bytes, re-encodes the result and writes all 72 bits back.

Reads are decoded in a registered stage. A single flipped bit anywhere in the 72-bit word is repaired in the returned data and reported. A double flip is reported as uncorrectable. If the old word fetched for a partial write cannot be repaired, the write is abandoned, memory is left as it was, and the response carries the uncorrectable flag. The requester issues one command at a time and waits for the one-cycle response pulse. The memory returns read data in the cycle after the read enable.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: Memory bits 63:0 hold the data and bit 64+j holds check bit j. Check bit j is the XOR of every data bit i whose column has bit j set. The columns for data bits 0..55 are the 8-bit values of weight three in increasing numeric order. The columns for data bits 56..63 are the eight smallest 8-bit values of weight five. Check bit j has the column with only bit j set.
- R2: A write whose mask is 8'hFF issues one memory write and no memory read. Its response pulse comes 2 cycles after the accepting edge.
- R3: A write whose mask is not 8'hFF issues one read and then one write of all 72 bits. Mask bit b selects data bits 8b+7:8b from the request, and the other bytes keep their old values. The response comes 4 cycles after acceptance.
- R4: A read returns the stored data 3 cycles after acceptance. For a clean word both status flags are 0.
- R5: A single flipped bit in any of the 72 stored bits is corrected in the read data, with rspCorrected=1 and rspUncorr=0.
- R6: Two flipped bits in a word give rspUncorr=1 and rspCorrected=0.
- R7: If the old word of a partial write is uncorrectable, no memory write takes place and the stored word stays as it was. The response comes 3 cycles after acceptance with rspUncorr=1.
- R8: A correctable old word in a partial write is repaired before the merge. The stored result is a clean code word, and the response carries rspCorrected=1.
- R9: reqReady is high only while the block is idle. rspValid is a single-cycle pulse, and write responses return zero data.
- R10: During reset, reqReady=1, rspValid=0 and both memory enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Command present |
| reqReady | output | 1 | Block idle and accepting a command |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWData | input | 64 | Write data |
| reqMask | input | 8 | Byte enables for writes |
| rspValid | output | 1 | Response pulse |
| rspRdata | output | 64 | Corrected read data, zero for writes |
| rspCorrected | output | 1 | A single-bit error was repaired |
| rspUncorr | output | 1 | Uncorrectable error, or write abandoned |
| memRdEn | output | 1 | Memory read enable |
| memWrEn | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory word address |
| memWrData | output | 72 | Encoded word to store |
| memRdData | input | 72 | Stored word, valid the cycle after memRdEn |

## Verification
The assertions check the command-level protocol on every cycle. A full-mask write must go straight to a write and never read. A partial write must begin with a read. Read and write enables must never be high together. A rejected partial write must not reach the memory. The response must be a lone pulse with no conflicting status flags. Only the bench scenarios can show the data side: that the check bits match the stated column map, that each of the 72 single-bit positions is repaired, that double flips are caught, and that merged bytes land in the right lanes, including after a repaired old word.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DataW    = 64;
  localparam int CheckW   = 8;
  localparam int CodeW    = DataW + CheckW;
  localparam int ByteW    = 8;
  localparam int NumBytes = DataW / ByteW;

  typedef logic [DataW-1:0][CheckW-1:0] hMat_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // register the incoming command
    logic latchOld;   // keep the repaired old word for merging
    logic rspRead;    // load read response from decoder
    logic rspWrite;   // load completed-write response
    logic rspAbort;   // load abandoned-write response
  } ctlStrobe_t;

  typedef enum logic [2:0] {StIdle, StRead, StCheck, StWrite, StResp} ctlState_t;

  // Weight-3 values in ascending order, then the smallest weight-5 values
  function automatic hMat_t buildMat();
    hMat_t m;
    int n;
    m = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 1; v < 256; v++) begin
        if ($countones(v[7:0]) == w) begin
          if (n < DataW) m[n] = v[7:0];
          n++;
        end
      end
    end
    return m;
  endfunction

  localparam hMat_t HMat = buildMat();

  function automatic logic [CheckW-1:0] calcCheck(logic [DataW-1:0] d);
    logic [CheckW-1:0] c;
    c = '0;
    for (int i = 0; i < DataW; i++) begin
      if (d[i]) c = c ^ HMat[i];
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc_rmw_dec.sv
module ecc_rmw_dec
  import ecc_rmw_pkg::*;
(
  input  logic [CodeW-1:0] codeIn,
  output logic [DataW-1:0] dataFix,
  output logic             isCorrected,
  output logic             isUncorr
);
  logic [CheckW-1:0] syndrome;
  logic [DataW-1:0]  hitBit;
  logic              checkHit;

  assign syndrome = calcCheck(codeIn[DataW-1:0]) ^ codeIn[CodeW-1:DataW];

  for (genvar i = 0; i < DataW; i++) begin : g_hit
    assign hitBit[i] = (syndrome == HMat[i]);
  end

  assign checkHit    = $onehot(syndrome);
  assign dataFix     = codeIn[DataW-1:0] ^ hitBit;
  assign isCorrected = (|hitBit) | checkHit;
  assign isUncorr    = (syndrome != '0) && !isCorrected;
endmodule

// File: rtl/ecc_rmw_dp.sv
module ecc_rmw_dp
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DataW-1:0]    reqWData,
  input  logic [NumBytes-1:0] reqMask,
  input  logic [CodeW-1:0]    memRdData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [CodeW-1:0]    memWrData,
  output logic                decUncorr,
  output logic [DataW-1:0]    rspRdata,
  output logic                rspCorrected,
  output logic                rspUncorr
);
  logic [ADDR_W-1:0]   addrQ;
  logic [DataW-1:0]    wdataQ;
  logic [NumBytes-1:0] maskQ;
  logic [DataW-1:0]    oldFixQ;
  logic                oldCorrQ;
  logic [DataW-1:0]    decData;
  logic                decCorr;
  logic [DataW-1:0]    mergedData;

  ecc_rmw_dec u_dec (
    .codeIn      (memRdData),
    .dataFix     (decData),
    .isCorrected (decCorr),
    .isUncorr    (decUncorr)
  );

  for (genvar b = 0; b < NumBytes; b++) begin : g_merge
    assign mergedData[b*ByteW +: ByteW] = maskQ[b] ? wdataQ[b*ByteW +: ByteW]
                                                   : oldFixQ[b*ByteW +: ByteW];
  end

  assign memAddr   = addrQ;
  assign memWrData = {calcCheck(mergedData), mergedData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      maskQ    <= '0;
      oldFixQ  <= '0;
      oldCorrQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrQ    <= reqAddr;
        wdataQ   <= reqWData;
        maskQ    <= reqMask;
        oldCorrQ <= 1'b0;
      end
      if (strobe.latchOld) begin
        oldFixQ  <= decData;
        oldCorrQ <= decCorr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata     <= '0;
      rspCorrected <= 1'b0;
      rspUncorr    <= 1'b0;
    end else if (strobe.rspRead) begin
      rspRdata     <= decData;
      rspCorrected <= decCorr;
      rspUncorr    <= decUncorr;
    end else if (strobe.rspWrite) begin
      rspRdata     <= '0;
      rspCorrected <= oldCorrQ;
      rspUncorr    <= 1'b0;
    end else if (strobe.rspAbort) begin
      rspRdata     <= '0;
      rspCorrected <= 1'b0;
      rspUncorr    <= 1'b1;
    end
  end

  AST_ONE_RSP_SRC: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strobe.rspRead, strobe.rspWrite, strobe.rspAbort})) else $error("response sources overlap"); // R9
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rstN) strobe.rspAbort |=> rspUncorr && !rspCorrected && (rspRdata == '0)); // R7
endmodule

// File: rtl/ecc_rmw_ctl.sv
module ecc_rmw_ctl
  import ecc_rmw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [NumBytes-1:0] reqMask,
  input  logic                decUncorr,
  output logic                reqReady,
  output ctlStrobe_t          strobe,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic                rspValid
);
  ctlState_t stateQ, stateNext;
  logic      isWriteQ;
  logic      accept;
  logic      fullMask;

  assign accept   = reqValid && (stateQ == StIdle);
  assign fullMask = &reqMask;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    reqReady  = 1'b0;
    memRdEn   = 1'b0;
    memWrEn   = 1'b0;
    rspValid  = 1'b0;
    unique case (stateQ)
      StIdle: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext = (reqWrite && fullMask) ? StWrite : StRead;
        end
      end
      StRead: begin
        memRdEn   = 1'b1;
        stateNext = StCheck;
      end
      StCheck: begin
        if (!isWriteQ) begin
          strobe.rspRead = 1'b1;
          stateNext = StResp;
        end else if (decUncorr) begin
          strobe.rspAbort = 1'b1;
          stateNext = StResp;
        end else begin
          strobe.latchOld = 1'b1;
          stateNext = StWrite;
        end
      end
      StWrite: begin
        memWrEn         = 1'b1;
        strobe.rspWrite = 1'b1;
        stateNext       = StResp;
      end
      StResp: begin
        rspValid  = 1'b1;
        stateNext = StIdle;
      end
      default: stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= StIdle;
      isWriteQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (accept) isWriteQ <= reqWrite;
    end
  end

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(memRdEn && memWrEn)); // R3
  AST_FULL_NO_READ: assert property (@(posedge clk) disable iff (!rstN) (accept && reqWrite && fullMask) |=> memWrEn && !memRdEn); // R2
  AST_PARTIAL_READS: assert property (@(posedge clk) disable iff (!rstN) (accept && reqWrite && !fullMask) |=> memRdEn && !memWrEn); // R3
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) (stateQ == StCheck && isWriteQ && decUncorr) |=> !memWrEn && rspValid); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN) rspValid |=> !rspValid && reqReady); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN) (memRdEn || memWrEn || rspValid) |-> !reqReady); // R9
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DataW-1:0]    reqWData,
  input  logic [NumBytes-1:0] reqMask,
  output logic                rspValid,
  output logic [DataW-1:0]    rspRdata,
  output logic                rspCorrected,
  output logic                rspUncorr,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [CodeW-1:0]    memWrData,
  input  logic [CodeW-1:0]    memRdData
);
  ctlStrobe_t strobe;
  logic       decUncorr;

  ecc_rmw_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqMask   (reqMask),
    .decUncorr (decUncorr),
    .reqReady  (reqReady),
    .strobe    (strobe),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .rspValid  (rspValid)
  );

  ecc_rmw_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqWData     (reqWData),
    .reqMask      (reqMask),
    .memRdData    (memRdData),
    .memAddr      (memAddr),
    .memWrData    (memWrData),
    .decUncorr    (decUncorr),
    .rspRdata     (rspRdata),
    .rspCorrected (rspCorrected),
    .rspUncorr    (rspUncorr)
  );

  AST_FLAG_CLASH: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> !(rspCorrected && rspUncorr)); // R6
endmodule

// File: tb/sim_ecc_rmw_ctrl.sv
`timescale 1ns/1ps
module sim_ecc_rmw_ctrl;
  localparam int AW    = 4;
  localparam int WORDS = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic        reqReady;
  logic [AW-1:0] reqAddr;
  logic [63:0] reqWData;
  logic [7:0]  reqMask;
  logic        rspValid, rspCorrected, rspUncorr;
  logic [63:0] rspRdata;
  logic        memRdEn, memWrEn;
  logic [AW-1:0] memAddr;
  logic [71:0] memWrData, memRdData;

  always #2.5 clk = ~clk;

  ecc_rmw_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData), .reqMask(reqMask),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspCorrected(rspCorrected),
    .rspUncorr(rspUncorr), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  // Behavioural memory with one-cycle read latency and a bench poke port
  logic [71:0]   ram [WORDS];
  logic [71:0]   rdQ;
  logic          pokeEn;
  logic [AW-1:0] pokeAddr;
  logic [71:0]   pokeWord;

  always @(posedge clk) begin
    if (memWrEn) ram[memAddr] <= memWrData;
    if (pokeEn)  ram[pokeAddr] <= pokeWord;
    if (memRdEn) rdQ <= ram[memAddr];
  end
  assign memRdData = rdQ;

  int checks = 0;
  int errors = 0;
  logic [63:0] refData [WORDS];

  function automatic logic [7:0] tbCol(int idx);
    int n = 0;
    logic [7:0] r = '0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 1; v < 256; v++)
        if ($countones(8'(v)) == w) begin
          if (n == idx) r = 8'(v);
          n++;
        end
    return r;
  endfunction

  function automatic logic [71:0] tbEncode(logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= tbCol(i);
    return {c, d};
  endfunction

  function automatic logic [63:0] tbMerge(logic [63:0] oldD, logic [63:0] newD, logic [7:0] m);
    logic [63:0] r = oldD;
    for (int b = 0; b < 8; b++) if (m[b]) r[b*8 +: 8] = newD[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(int a, logic [71:0] w);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = AW'(a); pokeWord = w;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic doReq(bit wr, int a, logic [63:0] d, logic [7:0] m, int expLat,
                       int expRd, int expWr, bit chkData, logic [63:0] expData,
                       bit expC, bit expU, string req);
    int lat = 0;
    int rdCnt = 0;
    int wrCnt = 0;
    bit seen = 0;
    bit busyBad = 0;
    @(negedge clk);
    chk(reqReady == 1'b1, req, "ready before request", 72'(reqReady), 72'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqWData = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      if (memRdEn) rdCnt++;
      if (memWrEn) wrCnt++;
      if (reqReady) busyBad = 1;
      if (rspValid) begin
        seen = 1;
        lat = k;
        break;
      end
      @(negedge clk);
    end
    chk(seen && lat == expLat, req, "response latency", 72'(lat), 72'(expLat));
    chk(rdCnt == expRd, req, "memory reads", 72'(rdCnt), 72'(expRd));
    chk(wrCnt == expWr, req, "memory writes", 72'(wrCnt), 72'(expWr));
    chk(!busyBad, "R9", "ready while busy", 72'(busyBad), 72'd0);
    chk(rspCorrected == expC && rspUncorr == expU, req, "status flags",
        72'({rspCorrected, rspUncorr}), 72'({expC, expU}));
    if (chkData) chk(rspRdata == expData, req, "response data", 72'(rspRdata), 72'(expData));
    @(negedge clk);
    chk(!rspValid && reqReady, "R9", "single-cycle response", 72'({rspValid, reqReady}), 72'b01);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [71:0] bad;
    logic [63:0] d;
    logic [7:0]  masks [5];
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    reqWData = '0; reqMask = '0; pokeEn = 1'b0; pokeAddr = '0; pokeWord = '0;
    for (int a = 0; a < WORDS; a++) begin
      refData[a] = {32'(a) * 32'h9E3779B9, 32'hC0FFEE00 ^ 32'(a)};
      poke(a, tbEncode(refData[a]));
    end
    @(negedge clk);
    chk(reqReady && !rspValid && !memRdEn && !memWrEn, "R10", "reset outputs",
        72'({reqReady, rspValid, memRdEn, memWrEn}), 72'b1000);
    rstN = 1'b1;

    // R4: clean reads
    for (int a = 0; a < 4; a++)
      doReq(0, a, '0, '0, 3, 1, 0, 1, refData[a], 0, 0, "R4");

    // R2 and R1: full-mask write, stored check bits
    d = 64'h0123456789ABCDEF;
    doReq(1, 5, d, 8'hFF, 2, 0, 1, 1, '0, 0, 0, "R2");
    refData[5] = d;
    chk(ram[5] == tbEncode(d), "R1", "stored code word", ram[5], tbEncode(d));
    d = 64'hFFFF0000_A5A55A5A;
    doReq(1, 5, d, 8'hFF, 2, 0, 1, 0, '0, 0, 0, "R2");
    refData[5] = d;
    chk(ram[5] == tbEncode(d), "R1", "stored code word", ram[5], tbEncode(d));

    // R3: partial writes with several masks
    masks = '{8'h01, 8'hA5, 8'h00, 8'h7F, 8'h80};
    foreach (masks[i]) begin
      d = 64'hDEADBEEF_00000000 ^ (64'(i) * 64'h1111_2222_3333_4444);
      doReq(1, 6, d, masks[i], 4, 1, 1, 1, '0, 0, 0, "R3");
      refData[6] = tbMerge(refData[6], d, masks[i]);
      chk(ram[6] == tbEncode(refData[6]), "R3", "merged word", ram[6], tbEncode(refData[6]));
    end
    doReq(0, 6, '0, '0, 3, 1, 0, 1, refData[6], 0, 0, "R3");

    // R5: every single-bit position
    for (int b = 0; b < 72; b++) begin
      poke(7, tbEncode(refData[7]) ^ (72'd1 << b));
      doReq(0, 7, '0, '0, 3, 1, 0, 1, refData[7], 1, 0, "R5");
    end

    // R6: double-bit errors
    for (int b = 0; b < 72; b += 5) begin
      int b2 = (b * 7 + 5) % 72;
      if (b2 == b) b2 = (b + 1) % 72;
      poke(7, tbEncode(refData[7]) ^ (72'd1 << b) ^ (72'd1 << b2));
      doReq(0, 7, '0, '0, 3, 1, 0, 0, '0, 0, 1, "R6");
    end
    poke(7, tbEncode(refData[7]));

    // R7: partial write over an uncorrectable word is abandoned
    bad = tbEncode(refData[8]) ^ (72'd1 << 2) ^ (72'd1 << 50);
    poke(8, bad);
    doReq(1, 8, 64'h1234_5678_9ABC_DEF0, 8'h0F, 3, 1, 0, 1, '0, 0, 1, "R7");
    chk(ram[8] == bad, "R7", "location unchanged", ram[8], bad);
    bad = tbEncode(refData[8]) ^ (72'd1 << 64) ^ (72'd1 << 71);
    poke(8, bad);
    doReq(1, 8, 64'h0, 8'h01, 3, 1, 0, 1, '0, 0, 1, "R7");
    chk(ram[8] == bad, "R7", "location unchanged", ram[8], bad);

    // R8: repaired old word before merge (data bit and check bit)
    poke(9, tbEncode(refData[9]) ^ (72'd1 << 20));
    d = 64'hCAFEF00D_BAADC0DE;
    doReq(1, 9, d, 8'hF0, 4, 1, 1, 1, '0, 1, 0, "R8");
    refData[9] = tbMerge(refData[9], d, 8'hF0);
    chk(ram[9] == tbEncode(refData[9]), "R8", "clean merged word", ram[9], tbEncode(refData[9]));
    poke(10, tbEncode(refData[10]) ^ (72'd1 << 68));
    doReq(1, 10, d, 8'h3C, 4, 1, 1, 1, '0, 1, 0, "R8");
    refData[10] = tbMerge(refData[10], d, 8'h3C);
    chk(ram[10] == tbEncode(refData[10]), "R8", "clean merged word", ram[10], tbEncode(refData[10]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule